// File: doc/BRIEF.md
# Relative Branch Target Calculator

This block forms the destination address of a program-counter-relative branch for a processor with 8-bit opcodes and a 16-bit address space. Each request supplies the address of the instruction that follows the branch, a two-bit code for the kind of branch, the raw offset bytes, the loop postbyte and a flag saying whether the branch condition holds. The decoder and the condition logic sit outside this block.

Four kinds of branch are handled, and they use three offset widths. Short branches and bit-condition branches carry a signed byte. Long branches carry a signed 16-bit word. Loop primitives carry a signed 9-bit value: its sign comes from one bit of the postbyte and its low eight bits from the following byte.

The sum is registered once. One cycle after a request the block presents the target and the next program counter. The next program counter is the target when the condition holds and the sequential address when it does not. Both outputs hold their values between requests.

Top module: `rbt_calc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, target and npc_out are all zero.
- R2: For br_kind 0 (short), the target is next_pc plus off_lo read as a signed byte, giving a range of -128 to +127.
- R3: For br_kind 1 (long), the target is next_pc plus the signed 16-bit value {off_hi, off_lo}, giving a range of -32768 to +32767.
- R4: For br_kind 2 (loop), the offset is a signed 9-bit value. Bit 4 of loop_pb is its sign bit and off_lo holds its low eight bits, giving a range of -256 to +255. All other bits of loop_pb have no effect.
- R5: For br_kind 3 (bit-condition), the target is next_pc plus off_lo read as a signed byte. off_hi has no effect for any kind other than 1.
- R6: All address arithmetic wraps modulo 2^16.
- R7: npc_out equals the target when cond_true is 1 and equals next_pc when cond_true is 0.
- R8: A zero offset gives a target equal to next_pc for every kind.
- R9: Results appear exactly one cycle after a cycle with in_valid high, and out_valid is high only in that cycle. When in_valid is low, target and npc_out keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is present this cycle |
| br_kind | input | 2 | Branch kind: 0 short, 1 long, 2 loop, 3 bit-condition |
| next_pc | input | 16 | Address just past the whole branch instruction |
| off_hi | input | 8 | Upper offset byte (used by long branches only) |
| off_lo | input | 8 | Lower offset byte |
| loop_pb | input | 8 | Loop postbyte (bit 4 is the offset sign) |
| cond_true | input | 1 | The branch condition holds |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| target | output | 16 | Computed branch destination |
| npc_out | output | 16 | Next program counter value |

## Verification
Errors in the offset selection show up as a wrong target in the cycle after the request. A wrong sign or width choice moves the extreme offsets most, so each kind is tested at both ends of its range and across the 16-bit wrap. A stuck or mis-enabled output register shows up either as results that change during idle cycles or as out_valid staying high for more than one cycle. The bench checks both on the idle cycle that follows every request.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int KIND_W = 2;
    localparam int LOOP_SIGN_BIT = 4;

    typedef enum logic [KIND_W-1:0] {
        BK_SHORT = 2'd0,
        BK_LONG  = 2'd1,
        BK_LOOP  = 2'd2,
        BK_BITC  = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] npc;
    } rbt_state_t;
endpackage

// File: rtl/rbt_offset_sel.sv
module rbt_offset_sel
    import rbt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int SIGN_BIT = LOOP_SIGN_BIT
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [BW-1:0]     hi,
    input  logic [BW-1:0]     lo,
    input  logic              loop_sign,
    output logic [AW-1:0]     offset
);
    localparam int SHORT_PAD = AW - BW;
    localparam int LOOP_PAD  = AW - BW - 1;

    logic [AW-1:0] off_byte;
    logic [AW-1:0] off_word;
    logic [AW-1:0] off_loop;

    // Sign extension of a single byte (short and bit-condition kinds)
    assign off_byte = {{SHORT_PAD{lo[BW-1]}}, lo};

    // Long offset: two bytes, filled or cut to address width
    generate
        if (AW > 2 * BW) begin : g_word_ext
            assign off_word = {{(AW - 2 * BW){hi[BW-1]}}, hi, lo};
        end else begin : g_word_fit
            logic [2*BW-1:0] word_full;
            assign word_full = {hi, lo};
            assign off_word  = word_full[AW-1:0];
        end
    endgenerate

    // Loop offset: nine bits, sign taken from the postbyte
    assign off_loop = {{LOOP_PAD{loop_sign}}, loop_sign, lo};

    always_comb begin
        unique case (br_kind_e'(kind))
            BK_LONG: offset = off_word;
            BK_LOOP: offset = off_loop;
            default: offset = off_byte;
        endcase
    end
endmodule

// File: rtl/rbt_addr_add.sv
module rbt_addr_add #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic          cond,
    output logic [AW-1:0] sum,
    output logic [AW-1:0] next
);
    // Carry out of the top bit is dropped: modulo 2^AW wrap
    assign sum  = base + offset;
    assign next = cond ? sum : base;
endmodule

// File: rtl/rbt_calc.sv
module rbt_calc
    import rbt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int SIGN_BIT = LOOP_SIGN_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [KIND_W-1:0] br_kind,
    input  logic [AW-1:0]     next_pc,
    input  logic [BW-1:0]     off_hi,
    input  logic [BW-1:0]     off_lo,
    input  logic [BW-1:0]     loop_pb,
    input  logic              cond_true,
    output logic              out_valid,
    output logic [AW-1:0]     target,
    output logic [AW-1:0]     npc_out
);
    localparam logic [BW-1:0] SIGN_MASK = BW'(1) << SIGN_BIT;

    rbt_state_t    st_d;
    rbt_state_t    st_q;
    logic [AW-1:0] offset;
    logic [AW-1:0] sum;
    logic [AW-1:0] next_sel;
    logic          unused_pb_bits;

    assign unused_pb_bits = ^(loop_pb & ~SIGN_MASK);

    rbt_offset_sel #(
        .AW(AW), .BW(BW), .SIGN_BIT(SIGN_BIT)
    ) off_i (
        .kind      (br_kind),
        .hi        (off_hi),
        .lo        (off_lo),
        .loop_sign (loop_pb[SIGN_BIT]),
        .offset    (offset)
    );

    rbt_addr_add #(
        .AW(AW)
    ) add_i (
        .base   (next_pc),
        .offset (offset),
        .cond   (cond_true),
        .sum    (sum),
        .next   (next_sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.tgt = sum;
            st_d.npc = next_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign target    = st_q.tgt;
    assign npc_out   = st_q.npc;
endmodule

// File: rtl/rbt_calc_chk.sv
module rbt_calc_chk #(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int KW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [KW-1:0] br_kind,
    input logic [AW-1:0] next_pc,
    input logic [BW-1:0] off_hi,
    input logic [BW-1:0] off_lo,
    input logic          cond_true,
    input logic          out_valid,
    input logic [AW-1:0] target,
    input logic [AW-1:0] npc_out
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(target) && $stable(npc_out))); // R9
    AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_true) |=> (npc_out == $past(next_pc))); // R7
    AST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_true) |=> (npc_out == target)); // R7
    AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && off_lo == '0 && (br_kind != 2'd1 || off_hi == '0) && br_kind != 2'd2)
        |=> (target == $past(next_pc))); // R8
    AST_LONG_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind == 2'd1) |=> (target == $past(next_pc + {off_hi, off_lo}))); // R3
endmodule

bind rbt_calc rbt_calc_chk #(.AW(AW), .BW(BW), .KW(rbt_pkg::KIND_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .br_kind   (br_kind),
    .next_pc   (next_pc),
    .off_hi    (off_hi),
    .off_lo    (off_lo),
    .cond_true (cond_true),
    .out_valid (out_valid),
    .target    (target),
    .npc_out   (npc_out)
);

// File: tb/rbt_calc_tb_top.sv
`timescale 1ns/1ps
module rbt_calc_tb_top;
    localparam int NV = 16;
    // {kind[2], pc[16], hi[8], lo[8], pb[8], cond[1], exp_target[16]}
    localparam logic [58:0] VEC [NV] = '{
        {2'd0, 16'h1000, 8'h00, 8'h7F, 8'h00, 1'b1, 16'h107F}, // R2 +127
        {2'd0, 16'h1000, 8'h00, 8'h80, 8'h00, 1'b1, 16'h0F80}, // R2 -128
        {2'd0, 16'h1000, 8'hFF, 8'h00, 8'h00, 1'b1, 16'h1000}, // R8 R5 hi ignored
        {2'd1, 16'h1000, 8'h7F, 8'hFF, 8'h00, 1'b1, 16'h8FFF}, // R3 +32767
        {2'd1, 16'h9000, 8'h80, 8'h00, 8'h00, 1'b0, 16'h1000}, // R3 -32768
        {2'd1, 16'h1000, 8'h80, 8'h00, 8'h00, 1'b1, 16'h9000}, // R6 wrap
        {2'd2, 16'h2000, 8'h00, 8'hFF, 8'h01, 1'b1, 16'h20FF}, // R4 +255
        {2'd2, 16'h2000, 8'h00, 8'h00, 8'h10, 1'b1, 16'h1F00}, // R4 -256
        {2'd2, 16'h2000, 8'h00, 8'h05, 8'h11, 1'b1, 16'h1F05}, // R4 -251
        {2'd2, 16'h2000, 8'h77, 8'h05, 8'hEF, 1'b0, 16'h2005}, // R4 other pb bits
        {2'd3, 16'h3000, 8'h55, 8'h21, 8'h00, 1'b1, 16'h3021}, // R5
        {2'd3, 16'h3000, 8'h00, 8'h80, 8'hFF, 1'b1, 16'h2F80}, // R5 -128
        {2'd0, 16'hFFF0, 8'h00, 8'h20, 8'h00, 1'b1, 16'h0010}, // R6 up wrap
        {2'd0, 16'h0010, 8'h00, 8'hE0, 8'h00, 1'b0, 16'hFFF0}, // R6 down wrap
        {2'd2, 16'h4444, 8'hAA, 8'h00, 8'hEF, 1'b1, 16'h4444}, // R8 loop
        {2'd1, 16'hABCD, 8'h00, 8'h00, 8'h00, 1'b0, 16'hABCD}  // R8 long
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  br_kind = '0;
    logic [15:0] next_pc = '0;
    logic [7:0]  off_hi = '0;
    logic [7:0]  off_lo = '0;
    logic [7:0]  loop_pb = '0;
    logic        cond_true = 1'b0;
    logic        out_valid;
    logic [15:0] target;
    logic [15:0] npc_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rbt_calc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_kind(br_kind),
        .next_pc(next_pc), .off_hi(off_hi), .off_lo(off_lo), .loop_pb(loop_pb),
        .cond_true(cond_true), .out_valid(out_valid), .target(target), .npc_out(npc_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] h,
                         input logic [7:0] l, input logic [7:0] pb, input logic c);
        @(negedge clk);
        in_valid = 1'b1; br_kind = k; next_pc = pc;
        off_hi = h; off_lo = l; loop_pb = pb; cond_true = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] hold_t;
        logic [15:0] hold_n;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {15'd0, out_valid}, 16'd0);
        chk("R1 reset target", target, 16'd0);
        chk("R1 reset npc", npc_out, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset target", target, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [58:0] v;
            v = VEC[i];
            issue(v[58:57], v[56:41], v[40:33], v[32:25], v[24:17], v[16]);
            chk($sformatf("R2-5 vec %0d target", i), target, v[15:0]);
            chk($sformatf("R7 vec %0d npc", i), npc_out, v[16] ? v[15:0] : v[56:41]);
            chk($sformatf("R9 vec %0d valid", i), {15'd0, out_valid}, 16'd1);
            // idle cycle with disturbed inputs: outputs must hold
            hold_t = target;
            hold_n = npc_out;
            next_pc = ~next_pc; off_lo = ~off_lo; cond_true = ~cond_true;
            @(negedge clk);
            chk($sformatf("R9 vec %0d idle valid", i), {15'd0, out_valid}, 16'd0);
            chk($sformatf("R9 vec %0d hold target", i), target, hold_t);
            chk($sformatf("R9 vec %0d hold npc", i), npc_out, hold_n);
        end

        // back-to-back requests: each result one cycle later
        @(negedge clk);
        in_valid = 1'b1; br_kind = 2'd0; next_pc = 16'h5000; off_lo = 8'h10; cond_true = 1'b1;
        @(negedge clk);
        chk("R9 b2b first", target, 16'h5010);
        br_kind = 2'd3; next_pc = 16'h6000; off_lo = 8'hF0; cond_true = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 b2b second target", target, 16'h5FF0);
        chk("R7 b2b second npc", npc_out, 16'h6000);
        chk("R9 b2b valid", {15'd0, out_valid}, 16'd1);

        // reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset target", target, 16'd0);
        chk("R1 re-reset npc", npc_out, 16'd0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule